// File: doc/BRIEF.md
# Dual-Region Reconfiguration Manager

This block looks after two reconfigurable regions that hold interchangeable cipher implementations. One region is live: it encrypts and its result is routed to the block output. Meanwhile the other region is rewritten in the background. The block picks a new design at random from the pool, skipping the one that is live. It reads that design's configuration image out of on-chip block memory and streams it as 32-bit words, one per write cycle, into a configuration write port.

Once the last word is out, a request crosses from the fast loading clock into the slow encryption clock. It waits there until no encryption is running. Then the live region is exchanged in one encryption-clock edge and an acknowledge crosses back. Only after that acknowledge does the loading side accept the next load command. The encryption side counts completed encryptions between swaps, and the loading side reports which design sits in each region.

Top module: `dual_region_mgr`

## Requirements
- R1: After reset, region 0 is active, both regions report design 0, `ldBusy`, `cfgWrEn`, `encBusy` are low and `encSinceSwap` is 0.
- R2: The pool has 11 designs (0 to 10). A load command latches `rndByte`. The design loaded is i = `rndByte` mod 10, plus one when i is equal to or above the design in the active region. The active design is therefore never chosen.
- R3: Design d has an image of 4 + 2·d words starting at block-memory word address 32·d. It is written on consecutive `ldClk` cycles with `cfgWrEn` high. Word k is {8'hA5 in bits 31:24, d in bits 23:16, k in bits 15:0}, with k rising from 0.
- R4: `cfgWrEn` is high only while `ldBusy` is high. During writes, `cfgRegion` names the region that is not active.
- R5: When a load finishes, `activeRegion` switches to the freshly loaded region. `ldBusy` stays high until that switch has been acknowledged back into the loading domain.
- R6: The active region changes only at an `encClk` edge where no encryption is in progress. It takes effect at that single edge.
- R7: A `startLoad` pulse while `ldBusy` is high is ignored. Region designs and the written image are those of the first command.
- R8: `encResult` always equals `regionRes1` when `activeRegion` is 1 and `regionRes0` otherwise.
- R9: `encStart` is accepted only while `encBusy` is low. An accepted start raises `encBusy` at the next edge for exactly 12 `encClk` cycles. `encBusy` never rises without a start.
- R10: `encSinceSwap` increments when an encryption completes and returns to 0 when the active region changes.
- R11: Directly after a load is accepted, the status output of the non-active region shows the chosen design.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ldClk | input | 1 | Loading-domain clock |
| ldRstN | input | 1 | Loading-domain reset, active low |
| startLoad | input | 1 | Load command, one ldClk cycle |
| rndByte | input | 8 | Random value used to choose the design |
| cfgWrEn | output | 1 | Configuration word valid |
| cfgData | output | 32 | Configuration word |
| cfgRegion | output | 1 | Region being written |
| ldBusy | output | 1 | Load or swap handshake in progress |
| designInRegion0 | output | 4 | Design held by region 0 |
| designInRegion1 | output | 4 | Design held by region 1 |
| encClk | input | 1 | Encryption-domain clock |
| encRstN | input | 1 | Encryption-domain reset, active low |
| encStart | input | 1 | Start of one encryption |
| regionRes0 | input | 128 | Result from region 0 |
| regionRes1 | input | 128 | Result from region 1 |
| encResult | output | 128 | Result of the active region |
| activeRegion | output | 1 | Region currently encrypting |
| encBusy | output | 1 | Encryption in progress |
| encSinceSwap | output | 16 | Encryptions completed since the last swap |

## Verification
The properties assume that `encStart` and `startLoad` are synchronous single-cycle pulses in their own domains. They also assume that the two resets are released before the first command. The stimulus changes inputs only on falling edges of their own clock and leaves idle cycles wherever the protocol requires them. Encryption starts are random and may fall while `encBusy` is high, which exercises the rule that such starts are discarded. The random load values cover the full 8-bit range. Directed values hit the wrap of the modulo, the largest design and a second command issued during a load.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

  typedef enum logic [1:0] {
    LD_IDLE,
    LD_STREAM,
    LD_DRAIN,
    LD_WAIT
  } ldState_t;

  typedef struct packed {
    logic latch;    // accept a load command
    logic step;     // issue one memory read
    logic flipReq;  // toggle swap request
    logic ackTake;  // swap acknowledged
  } ldStrobe_t;

endpackage

// File: rtl/rcm_load_ctrl.sv
module rcm_load_ctrl
  import rcm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startLoad,
  input  logic      lastIssue,
  input  logic      ackSeen,
  output ldStrobe_t strobe,
  output logic      busy
);

  ldState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      LD_IDLE: if (startLoad) begin
        strobe.latch = 1'b1;
        stateNext    = LD_STREAM;
      end
      LD_STREAM: begin
        strobe.step = 1'b1;
        if (lastIssue) stateNext = LD_DRAIN;
      end
      LD_DRAIN: begin
        strobe.flipReq = 1'b1;
        stateNext      = LD_WAIT;
      end
      LD_WAIT: if (ackSeen) begin
        strobe.ackTake = 1'b1;
        stateNext      = LD_IDLE;
      end
      default: stateNext = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= LD_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != LD_IDLE);

endmodule

// File: rtl/rcm_load_path.sv
module rcm_load_path
  import rcm_pkg::*;
#(
  parameter int DESIGNS    = 11,
  parameter int SLOT_WORDS = 32,
  parameter int BASE_LEN   = 4,
  parameter int LEN_STEP   = 2,
  parameter int RND_W      = 8,
  parameter int CFG_W      = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ldStrobe_t                  strobe,
  input  logic [RND_W-1:0]           rndByte,
  input  logic                       ackTogIn,
  output logic                       reqTog,
  output logic                       ackSeen,
  output logic                       lastIssue,
  output logic                       cfgWrEn,
  output logic [CFG_W-1:0]           cfgData,
  output logic                       cfgRegion,
  output logic [$clog2(DESIGNS)-1:0] designReg0,
  output logic [$clog2(DESIGNS)-1:0] designReg1
);

  localparam int DES_W  = $clog2(DESIGNS);
  localparam int ADDR_W = $clog2(DESIGNS * SLOT_WORDS);
  localparam int LEN_W  = $clog2(SLOT_WORDS + 1);

  // Block-memory content is a function of the address: each slot holds one image.
  function automatic logic [CFG_W-1:0] imgWord(input logic [ADDR_W-1:0] a);
    logic [7:0]  dSel;
    logic [15:0] off;
    dSel = 8'(a / SLOT_WORDS);
    off  = 16'(a % SLOT_WORDS);
    return CFG_W'({8'hA5, dSel, off});
  endfunction

  logic [DES_W-1:0]  regDesign [2];
  logic              viewActive;
  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remain;
  logic [CFG_W-1:0]  romData;
  logic              wrValid;
  logic [2:0]        ackSync;

  logic [RND_W-1:0]  modVal;
  logic [DES_W-1:0]  pickIdx, activeDesign, pickDesign;

  assign modVal       = rndByte % RND_W'(DESIGNS - 1);
  assign pickIdx      = DES_W'(modVal);
  assign activeDesign = regDesign[viewActive];
  assign pickDesign   = (pickIdx >= activeDesign) ? pickIdx + DES_W'(1) : pickIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regDesign[0] <= '0;
      regDesign[1] <= '0;
      viewActive   <= 1'b0;
      curAddr      <= '0;
      remain       <= '0;
      romData      <= '0;
      wrValid      <= 1'b0;
      reqTog       <= 1'b0;
      ackSync      <= '0;
    end else begin
      ackSync <= {ackSync[1:0], ackTogIn};
      wrValid <= strobe.step;
      if (strobe.latch) begin
        regDesign[~viewActive] <= pickDesign;
        curAddr <= ADDR_W'(pickDesign * SLOT_WORDS);
        remain  <= LEN_W'(BASE_LEN + LEN_STEP * pickDesign);
      end
      if (strobe.step) begin
        romData <= imgWord(curAddr);
        curAddr <= curAddr + ADDR_W'(1);
        remain  <= remain - LEN_W'(1);
      end
      if (strobe.flipReq) reqTog     <= ~reqTog;
      if (strobe.ackTake) viewActive <= ~viewActive;
    end
  end

  assign ackSeen    = ackSync[2] ^ ackSync[1];
  assign lastIssue  = (remain == LEN_W'(1));
  assign cfgWrEn    = wrValid;
  assign cfgData    = romData;
  assign cfgRegion  = ~viewActive;
  assign designReg0 = regDesign[0];
  assign designReg1 = regDesign[1];

endmodule

// File: rtl/rcm_enc_side.sv
module rcm_enc_side #(
  parameter int ENC_CYCLES = 12,
  parameter int CNT_W      = 16,
  parameter int RES_W      = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqTogIn,
  input  logic             encStart,
  input  logic [RES_W-1:0] regionRes0,
  input  logic [RES_W-1:0] regionRes1,
  output logic             ackTog,
  output logic             activeRegion,
  output logic             encBusy,
  output logic [CNT_W-1:0] encSinceSwap,
  output logic [RES_W-1:0] encResult
);

  localparam int CYC_W = $clog2(ENC_CYCLES + 1);

  logic [2:0]       reqSync;
  logic             reqEdge, pending, swapNow, running;
  logic [CYC_W-1:0] cycLeft;

  assign reqEdge = reqSync[2] ^ reqSync[1];
  assign running = (cycLeft != '0);
  assign swapNow = pending && !running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqSync      <= '0;
      pending      <= 1'b0;
      activeRegion <= 1'b0;
      ackTog       <= 1'b0;
      encSinceSwap <= '0;
      cycLeft      <= '0;
    end else begin
      reqSync <= {reqSync[1:0], reqTogIn};
      if (reqEdge)      pending <= 1'b1;
      else if (swapNow) pending <= 1'b0;

      if (swapNow) begin
        activeRegion <= ~activeRegion;
        ackTog       <= ~ackTog;
        encSinceSwap <= '0;
      end else if (cycLeft == CYC_W'(1)) begin
        encSinceSwap <= encSinceSwap + CNT_W'(1);
      end

      if (running)       cycLeft <= cycLeft - CYC_W'(1);
      else if (encStart) cycLeft <= CYC_W'(ENC_CYCLES);
    end
  end

  assign encBusy   = running;
  assign encResult = activeRegion ? regionRes1 : regionRes0;

endmodule

// File: rtl/dual_region_mgr.sv
module dual_region_mgr
  import rcm_pkg::*;
#(
  parameter int DESIGNS    = 11,
  parameter int SLOT_WORDS = 32,
  parameter int BASE_LEN   = 4,
  parameter int LEN_STEP   = 2,
  parameter int RND_W      = 8,
  parameter int CFG_W      = 32,
  parameter int ENC_CYCLES = 12,
  parameter int CNT_W      = 16,
  parameter int RES_W      = 128
) (
  input  logic                       ldClk,
  input  logic                       ldRstN,
  input  logic                       startLoad,
  input  logic [RND_W-1:0]           rndByte,
  output logic                       cfgWrEn,
  output logic [CFG_W-1:0]           cfgData,
  output logic                       cfgRegion,
  output logic                       ldBusy,
  output logic [$clog2(DESIGNS)-1:0] designInRegion0,
  output logic [$clog2(DESIGNS)-1:0] designInRegion1,
  input  logic                       encClk,
  input  logic                       encRstN,
  input  logic                       encStart,
  input  logic [RES_W-1:0]           regionRes0,
  input  logic [RES_W-1:0]           regionRes1,
  output logic [RES_W-1:0]           encResult,
  output logic                       activeRegion,
  output logic                       encBusy,
  output logic [CNT_W-1:0]           encSinceSwap
);

  ldStrobe_t strobe;
  logic      lastIssue, ackSeen, reqTog, ackTog;

  rcm_load_ctrl uCtrl (
    .clk(ldClk), .rstN(ldRstN), .startLoad(startLoad),
    .lastIssue(lastIssue), .ackSeen(ackSeen),
    .strobe(strobe), .busy(ldBusy)
  );

  rcm_load_path #(
    .DESIGNS(DESIGNS), .SLOT_WORDS(SLOT_WORDS), .BASE_LEN(BASE_LEN),
    .LEN_STEP(LEN_STEP), .RND_W(RND_W), .CFG_W(CFG_W)
  ) uPath (
    .clk(ldClk), .rstN(ldRstN), .strobe(strobe), .rndByte(rndByte),
    .ackTogIn(ackTog), .reqTog(reqTog), .ackSeen(ackSeen),
    .lastIssue(lastIssue), .cfgWrEn(cfgWrEn), .cfgData(cfgData),
    .cfgRegion(cfgRegion), .designReg0(designInRegion0),
    .designReg1(designInRegion1)
  );

  rcm_enc_side #(
    .ENC_CYCLES(ENC_CYCLES), .CNT_W(CNT_W), .RES_W(RES_W)
  ) uEnc (
    .clk(encClk), .rstN(encRstN), .reqTogIn(reqTog), .encStart(encStart),
    .regionRes0(regionRes0), .regionRes1(regionRes1), .ackTog(ackTog),
    .activeRegion(activeRegion), .encBusy(encBusy),
    .encSinceSwap(encSinceSwap), .encResult(encResult)
  );

endmodule

// File: rtl/rcm_checker.sv
module rcm_checker #(
  parameter int DESIGNS = 11,
  parameter int CNT_W   = 16
) (
  input logic                       ldClk,
  input logic                       ldRstN,
  input logic                       cfgWrEn,
  input logic                       ldBusy,
  input logic [$clog2(DESIGNS)-1:0] designInRegion0,
  input logic [$clog2(DESIGNS)-1:0] designInRegion1,
  input logic                       encClk,
  input logic                       encRstN,
  input logic                       encStart,
  input logic                       encBusy,
  input logic                       activeRegion,
  input logic [CNT_W-1:0]           encSinceSwap
);

  assert_wr_in_load_R4: assert property (@(posedge ldClk) disable iff (!ldRstN)
    cfgWrEn |-> ldBusy);

  assert_pick_differs_R2: assert property (@(posedge ldClk) disable iff (!ldRstN)
    ldBusy |-> (designInRegion0 != designInRegion1));

  assert_design_range_R11: assert property (@(posedge ldClk) disable iff (!ldRstN)
    (int'(designInRegion0) < DESIGNS) && (int'(designInRegion1) < DESIGNS));

  assert_ignore_busy_R7: assert property (@(posedge ldClk) disable iff (!ldRstN)
    (ldBusy && $past(ldBusy)) |-> ($stable(designInRegion0) && $stable(designInRegion1)));

  assert_swap_boundary_R6: assert property (@(posedge encClk) disable iff (!encRstN)
    !$stable(activeRegion) |-> !$past(encBusy));

  assert_start_needed_R9: assert property (@(posedge encClk) disable iff (!encRstN)
    $rose(encBusy) |-> $past(encStart));

  assert_count_step_R10: assert property (@(posedge encClk) disable iff (!encRstN)
    $fell(encBusy) |-> (encSinceSwap == CNT_W'($past(encSinceSwap) + 1)));

endmodule

bind dual_region_mgr rcm_checker #(.DESIGNS(DESIGNS), .CNT_W(CNT_W)) uChk (
  .ldClk(ldClk), .ldRstN(ldRstN), .cfgWrEn(cfgWrEn), .ldBusy(ldBusy),
  .designInRegion0(designInRegion0), .designInRegion1(designInRegion1),
  .encClk(encClk), .encRstN(encRstN), .encStart(encStart), .encBusy(encBusy),
  .activeRegion(activeRegion), .encSinceSwap(encSinceSwap)
);

// File: tb/sim_dual_region_mgr.sv
module sim_dual_region_mgr;

  logic         ldClk = 1'b0, encClk = 1'b0;
  logic         ldRstN = 1'b0, encRstN = 1'b0;
  logic         startLoad = 1'b0;
  logic [7:0]   rndByte = '0;
  logic         cfgWrEn, cfgRegion, ldBusy;
  logic [31:0]  cfgData;
  logic [3:0]   designInRegion0, designInRegion1;
  logic         encStart = 1'b0;
  logic [127:0] regionRes0 = '0, regionRes1 = '0;
  logic [127:0] encResult;
  logic         activeRegion, encBusy;
  logic [15:0]  encSinceSwap;

  always #10 ldClk = ~ldClk;   // 50 MHz
  always #50 encClk = ~encClk;

  dual_region_mgr u0 (.*);

  int checks = 0, fails = 0, ldCycle = 0;
  bit started = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mapD(input int r, input int act);
    int i;
    i = r % 10;
    if (i >= act) i++;
    return i;
  endfunction

  // watchdog
  always @(posedge ldClk) begin
    ldCycle++;
    if (ldCycle > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", ldCycle, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // configuration write log
  logic [31:0] wrLog [64];
  int          wrStamp [64];
  bit          wrReg [64];
  int          logIdx = 0;
  always @(negedge ldClk) begin
    if (started && cfgWrEn) begin
      wrLog[logIdx % 64]   = cfgData;
      wrStamp[logIdx % 64] = ldCycle;
      wrReg[logIdx % 64]   = cfgRegion;
      logIdx++;
      chk(ldBusy, "R4 write outside load", ldBusy, 1);
    end
  end

  // encryption-domain monitor and driver
  bit prevActive = 0, prevBusy = 0, prevStart = 0;
  int runLen = 0, expCount = 0;
  always @(negedge encClk) begin
    if (started) begin
      chk(encResult == (activeRegion ? regionRes1 : regionRes0), "R8 mux",
          encResult, activeRegion ? regionRes1 : regionRes0);
      if (activeRegion != prevActive) begin
        chk(!prevBusy, "R6 swap during encryption", prevBusy, 0);
        expCount = 0;
      end else if (prevBusy && !encBusy) begin
        expCount++;
      end
      if (encBusy && !prevBusy) chk(prevStart, "R9 busy without start", prevStart, 1);
      if (encBusy) runLen++;
      else if (prevBusy) begin
        chk(runLen == 12, "R9 encryption length", runLen, 12);
        runLen = 0;
      end
      if (activeRegion != prevActive || (prevBusy && !encBusy))
        chk(encSinceSwap == 16'(expCount), "R10 count", encSinceSwap, expCount);
      prevActive = activeRegion;
      prevBusy   = encBusy;
      encStart   = ($urandom % 3) == 0;
      prevStart  = encStart;
      regionRes0 = {$urandom, $urandom, $urandom, $urandom};
      regionRes1 = {$urandom, $urandom, $urandom, $urandom};
    end
  end

  int  actDesign = 0;
  bit  expActive = 0;
  int  desModel [2] = '{0, 0};

  task automatic doLoad(input int rnd, input bit inject);
    int d, startIdx, n, len;
    bit tgt, okW, okR;
    while (ldBusy) @(negedge ldClk);
    d   = mapD(rnd & 255, actDesign);
    tgt = ~expActive;
    len = 4 + 2 * d;
    startIdx = logIdx;
    startLoad = 1'b1; rndByte = 8'(rnd);
    @(negedge ldClk);
    startLoad = 1'b0;
    chk(ldBusy, "R2 load accepted", ldBusy, 1);
    chk((tgt ? designInRegion1 : designInRegion0) == 4'(d), "R11 R2 chosen design",
        tgt ? designInRegion1 : designInRegion0, d);
    chk(d != actDesign, "R2 active design skipped", d, actDesign);
    if (inject) begin
      repeat (3) @(negedge ldClk);
      startLoad = 1'b1; rndByte = 8'(rnd + 3);
      @(negedge ldClk);
      startLoad = 1'b0;
    end
    while (ldBusy) @(negedge ldClk);
    n = logIdx - startIdx;
    chk(n == len, "R3 image length", n, len);
    okW = 1; okR = 1;
    for (int k = 0; k < n && k < 32; k++) begin
      if (wrLog[(startIdx + k) % 64] != {8'hA5, 8'(d), 16'(k)}) okW = 0;
      if (wrStamp[(startIdx + k) % 64] != wrStamp[startIdx % 64] + k) okW = 0;
      if (wrReg[(startIdx + k) % 64] != tgt) okR = 0;
    end
    chk(okW, "R3 image words", wrLog[startIdx % 64], {8'hA5, 8'(d), 16'h0});
    chk(okR, "R4 target region", wrReg[startIdx % 64], tgt);
    chk(activeRegion == tgt, "R5 active swapped", activeRegion, tgt);
    desModel[tgt] = d;
    expActive = tgt;
    actDesign = d;
    chk(designInRegion0 == 4'(desModel[0]) && designInRegion1 == 4'(desModel[1]),
        inject ? "R7 designs after ignored start" : "R11 designs",
        {designInRegion1, designInRegion0}, {4'(desModel[1]), 4'(desModel[0])});
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge encClk);
    ldRstN = 1'b1; encRstN = 1'b1;
    @(negedge ldClk);
    chk(!ldBusy && !cfgWrEn, "R1 load side idle", {ldBusy, cfgWrEn}, 0);
    chk(activeRegion == 0 && !encBusy && encSinceSwap == 0, "R1 enc side idle",
        {activeRegion, encBusy, encSinceSwap}, 0);
    chk(designInRegion0 == 0 && designInRegion1 == 0, "R1 designs",
        {designInRegion1, designInRegion0}, 0);
    started = 1'b1;
    doLoad(0, 0);    // active 0 -> design 1
    doLoad(255, 0);  // 5 >= 1 -> design 6
    doLoad(9, 0);    // 9 >= 6 -> design 10, longest image
    doLoad(10, 1);   // wraps to 0, second start ignored
    doLoad(0, 0);    // active 0 -> design 1
    for (int i = 0; i < 20; i++) doLoad(int'($urandom % 256), (i % 5) == 2);
    repeat (40) @(negedge encClk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule